// File: doc/BRIEF.md
# Packed Complex Multiply Unit

This block is a pipelined arithmetic unit for packed fixed-point complex data. Each 32-bit word carries one complex value. The upper half is the real part and the lower half is the imaginary part, both signed Q15 numbers. On every cycle an opcode picks one of several operations:

- a single complex product, either rounded or at full width;
- two independent rounded products;
- a rounded product with the conjugate of the second operand;
- a 1×2 complex row vector multiplied by a 2×2 complex matrix, rounded or not, with an optional conjugate of the vector.

The unit has a fixed latency of three cycles. It accepts a new operation on every cycle, so a caller can stream operands with no gaps. The output is a 128-bit bus made of four 32-bit lanes. Lanes that an operation does not use are driven to zero.

Top module: `cmx_mul_unit`

## Requirements
- R1: Operand A has word a0 in bits 31:0 and word a1 in bits 63:32. Operand B has words b0..b3, with bk in bits 32k+31:32k, and the matrix is [[b0 b1],[b2 b3]]. In every word, bits 31:16 hold the real part and bits 15:0 hold the imaginary part, both in two's complement. Result lane k is bits 32k+31:32k. Every lane not named below reads zero.
- R2: Opcode 0 computes a0·b0 at full width. Lane 0 holds the 32-bit real part and lane 1 holds the 32-bit imaginary part.
- R3: Opcode 1 computes a0·b0 rounded. Lane 0 holds {real, imag}, each 16 bits. Rounding adds 2^15 to the full sum, shifts it right arithmetically by 16 and saturates it to the 16-bit signed range. A sum of exactly +2^15 rounds to 1, and a sum of −2^15 rounds to 0.
- R4: Opcode 2 computes two products in the same operation: lane 0 holds the rounded a0·b0 and lane 1 holds the rounded a1·b1.
- R5: Opcode 3 computes the rounded a0·conj(b0) in lane 0. When a0 = b0 = (−1, −1), the real part saturates and lane 0 is 0x7FFF0000.
- R6: Opcode 4 computes y0 = a0·b0 + a1·b2 and y1 = a0·b1 + a1·b3, each summed at full width. Lanes 0..3 hold y0 real, y0 imag, y1 real and y1 imag, each saturated to the 32-bit signed range.
- R7: Opcode 5 computes the same y0 and y1 as opcode 4, rounded as in R3. Lane 0 holds y0 and lane 1 holds y1.
- R8: Opcodes 6 and 7 behave like opcodes 4 and 5, except that conj(a0) and conj(a1) replace the vector entries.
- R9: A result appears with outValid high exactly 3 cycles after its operation is accepted. Operations issued on consecutive cycles each produce their own result on consecutive cycles.
- R10: While outValid is low, including throughout reset, the whole result bus is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opcode | input | 3 | Operation select (0..7) |
| opA | input | 64 | Vector or first operands a1:a0 |
| opB | input | 128 | Second operands or matrix b3..b0 |
| outValid | output | 1 | Result valid |
| result | output | 128 | Four 32-bit result lanes |

## Verification
The assertions assume that inValid stays low during reset. They also assume that the opcode presented together with inValid is the one whose lane layout they check three cycles later. The bench drives inputs only at falling edges and keeps inValid low while reset is asserted, so the latency and lane-occupancy properties line up with the cycle in which each operation was accepted. The operand patterns include the most negative Q15 value in both parts. This exercises the saturating corners of the rounded, conjugate and matrix forms without depending on any other input assumption.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MULR  = 3'd1,
    OP_DUALR = 3'd2,
    OP_CONJR = 3'd3,
    OP_MAT   = 3'd4,
    OP_MATR  = 3'd5,
    OP_MATC  = 3'd6,
    OP_MATCR = 3'd7
  } cmxOp_e;

  // full decode of one operation, held for one stage in control
  typedef struct packed {
    logic valid;
    logic conjA;
    logic conjB;
    logic dual;
    logic matrix;
    logic rounded;
  } cmxDec_t;

  // strobe for operand routing ahead of the partial products
  typedef struct packed {
    logic dualRoute;
  } cmxRoute_t;

  // strobes for the summation stage
  typedef struct packed {
    logic conjA;
    logic conjB;
    logic matrix;
  } cmxMix_t;

  // strobes for the output formatting stage
  typedef struct packed {
    logic valid;
    logic rounded;
    logic wide;
  } cmxFmt_t;

endpackage

// File: rtl/cmx_ctrl.sv
module cmx_ctrl
  import cmx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [2:0] opcode,
  output cmxRoute_t route,
  output cmxMix_t   mix,
  output cmxFmt_t   fmt,
  output logic      outValid
);

  cmxDec_t dec0;
  cmxDec_t dec1;

  always_comb begin
    dec0 = '0;
    dec0.valid = inValid;
    unique case (cmxOp_e'(opcode))
      OP_MUL:   ;
      OP_MULR:  dec0.rounded = 1'b1;
      OP_DUALR: begin dec0.dual = 1'b1; dec0.rounded = 1'b1; end
      OP_CONJR: begin dec0.conjB = 1'b1; dec0.rounded = 1'b1; end
      OP_MAT:   dec0.matrix = 1'b1;
      OP_MATR:  begin dec0.matrix = 1'b1; dec0.rounded = 1'b1; end
      OP_MATC:  begin dec0.matrix = 1'b1; dec0.conjA = 1'b1; end
      OP_MATCR: begin dec0.matrix = 1'b1; dec0.conjA = 1'b1; dec0.rounded = 1'b1; end
      default:  ;
    endcase
  end

  assign route.dualRoute = dec0.dual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dec1     <= '0;
      fmt      <= '0;
      outValid <= 1'b0;
    end else begin
      dec1        <= dec0;
      fmt.valid   <= dec1.valid;
      fmt.rounded <= dec1.rounded;
      fmt.wide    <= dec1.dual | dec1.matrix;
      outValid    <= fmt.valid;
    end
  end

  assign mix.conjA  = dec1.conjA;
  assign mix.conjB  = dec1.conjB;
  assign mix.matrix = dec1.matrix;

endmodule

// File: rtl/cmx_cprod.sv
module cmx_cprod #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PROD_W = 2 * HALF_W
) (
  input  logic                     clk,
  input  logic [WORD_W-1:0]        aWord,
  input  logic [WORD_W-1:0]        bWord,
  output logic signed [PROD_W-1:0] prodRR,
  output logic signed [PROD_W-1:0] prodII,
  output logic signed [PROD_W-1:0] prodRI,
  output logic signed [PROD_W-1:0] prodIR
);

  logic signed [HALF_W-1:0] aRe, aIm, bRe, bIm;

  assign aRe = aWord[WORD_W-1:HALF_W];
  assign aIm = aWord[HALF_W-1:0];
  assign bRe = bWord[WORD_W-1:HALF_W];
  assign bIm = bWord[HALF_W-1:0];

  always_ff @(posedge clk) begin
    prodRR <= aRe * bRe;
    prodII <= aIm * bIm;
    prodRI <= aRe * bIm;
    prodIR <= aIm * bRe;
  end

endmodule

// File: rtl/cmx_datapath.sv
module cmx_datapath
  import cmx_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PROD_W = 2 * HALF_W,
  localparam int SUM_W  = 2 * HALF_W + 3,
  localparam int NPROD  = 4,
  localparam int NVEC   = 2,
  localparam int OUT_W  = NPROD * WORD_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cmxRoute_t               route,
  input  cmxMix_t                 mix,
  input  cmxFmt_t                 fmt,
  input  logic [NVEC*WORD_W-1:0]  opA,
  input  logic [NPROD*WORD_W-1:0] opB,
  output logic [OUT_W-1:0]        result
);

  localparam logic signed [SUM_W-1:0] RND_BIAS = SUM_W'(1) <<< (HALF_W - 1);
  localparam logic signed [SUM_W-1:0] HALF_MAX = RND_BIAS - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] HALF_MIN = -RND_BIAS;
  localparam logic signed [SUM_W-1:0] WORD_MAX = (SUM_W'(1) <<< (WORD_W - 1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] WORD_MIN = -WORD_MAX - SUM_W'(1);

  function automatic logic signed [SUM_W-1:0] sx(input logic signed [PROD_W-1:0] v);
    return {{(SUM_W-PROD_W){v[PROD_W-1]}}, v};
  endfunction

  function automatic logic [HALF_W-1:0] rndSat(input logic signed [SUM_W-1:0] x);
    logic signed [SUM_W-1:0] t;
    t = (x + RND_BIAS) >>> HALF_W;
    if (t > HALF_MAX)      t = HALF_MAX;
    else if (t < HALF_MIN) t = HALF_MIN;
    return t[HALF_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] satWord(input logic signed [SUM_W-1:0] x);
    logic signed [SUM_W-1:0] t;
    t = x;
    if (t > WORD_MAX)      t = WORD_MAX;
    else if (t < WORD_MIN) t = WORD_MIN;
    return t[WORD_W-1:0];
  endfunction

  // ---------------- stage 0: operand routing ----------------
  logic [WORD_W-1:0] aRoute [NPROD];
  logic [WORD_W-1:0] bRoute [NPROD];

  always_comb begin
    for (int k = 0; k < NPROD; k++) begin
      aRoute[k] = opA[(k / 2) * WORD_W +: WORD_W];
      bRoute[k] = opB[k * WORD_W +: WORD_W];
    end
    // dual mode pairs a1 with b1 on product slot 2
    if (route.dualRoute) bRoute[2] = opB[WORD_W +: WORD_W];
  end

  // ---------------- stage 1: partial products ----------------
  logic signed [PROD_W-1:0] ppRR [NPROD];
  logic signed [PROD_W-1:0] ppII [NPROD];
  logic signed [PROD_W-1:0] ppRI [NPROD];
  logic signed [PROD_W-1:0] ppIR [NPROD];

  for (genvar gP = 0; gP < NPROD; gP++) begin : g_prod
    cmx_cprod #(.HALF_W(HALF_W)) u_prod (
      .clk    (clk),
      .aWord  (aRoute[gP]),
      .bWord  (bRoute[gP]),
      .prodRR (ppRR[gP]),
      .prodII (ppII[gP]),
      .prodRI (ppRI[gP]),
      .prodIR (ppIR[gP])
    );
  end

  // ---------------- stage 2: complex sums ----------------
  logic signed [SUM_W-1:0] cRe [NPROD];
  logic signed [SUM_W-1:0] cIm [NPROD];
  logic signed [SUM_W-1:0] z0ReD, z0ImD, z1ReD, z1ImD;
  logic signed [SUM_W-1:0] z0Re, z0Im, z1Re, z1Im;

  always_comb begin
    for (int k = 0; k < NPROD; k++) begin
      if (mix.conjA || mix.conjB) cRe[k] = sx(ppRR[k]) + sx(ppII[k]);
      else                        cRe[k] = sx(ppRR[k]) - sx(ppII[k]);
      if (mix.conjB)      cIm[k] = sx(ppIR[k]) - sx(ppRI[k]);
      else if (mix.conjA) cIm[k] = sx(ppRI[k]) - sx(ppIR[k]);
      else                cIm[k] = sx(ppRI[k]) + sx(ppIR[k]);
    end
    if (mix.matrix) begin
      z0ReD = cRe[0] + cRe[2];
      z0ImD = cIm[0] + cIm[2];
      z1ReD = cRe[1] + cRe[3];
      z1ImD = cIm[1] + cIm[3];
    end else begin
      z0ReD = cRe[0];
      z0ImD = cIm[0];
      z1ReD = cRe[2];
      z1ImD = cIm[2];
    end
  end

  always_ff @(posedge clk) begin
    z0Re <= z0ReD;
    z0Im <= z0ImD;
    z1Re <= z1ReD;
    z1Im <= z1ImD;
  end

  // ---------------- stage 3: rounding, saturation, packing ----------------
  logic [OUT_W-1:0] packedD;

  always_comb begin
    packedD = '0;
    if (fmt.valid) begin
      if (fmt.rounded) begin
        packedD[0 +: WORD_W] = {rndSat(z0Re), rndSat(z0Im)};
        if (fmt.wide) packedD[WORD_W +: WORD_W] = {rndSat(z1Re), rndSat(z1Im)};
      end else begin
        packedD[0 +: WORD_W]      = satWord(z0Re);
        packedD[WORD_W +: WORD_W] = satWord(z0Im);
        if (fmt.wide) begin
          packedD[2*WORD_W +: WORD_W] = satWord(z1Re);
          packedD[3*WORD_W +: WORD_W] = satWord(z1Im);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= packedD;
  end

endmodule

// File: rtl/cmx_mul_unit.sv
module cmx_mul_unit
  import cmx_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opcode,
  input  logic [2*WORD_W-1:0] opA,
  input  logic [4*WORD_W-1:0] opB,
  output logic              outValid,
  output logic [4*WORD_W-1:0] result
);

  cmxRoute_t route;
  cmxMix_t   mix;
  cmxFmt_t   fmt;

  cmx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (opcode),
    .route    (route),
    .mix      (mix),
    .fmt      (fmt),
    .outValid (outValid)
  );

  cmx_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .route  (route),
    .mix    (mix),
    .fmt    (fmt),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/cmx_mul_unit_checker.sv
module cmx_mul_unit_checker (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [2:0]   opcode,
  input logic         outValid,
  input logic [127:0] result
);

  logic [1:0] rstAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rstAge <= 2'd0;
    else if (rstAge != 2'd3) rstAge <= rstAge + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (rstAge == 2'd3) |-> (outValid == $past(inValid, 3))); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (result == '0)); // R10

  AST_SINGLE_LANE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    ((rstAge == 2'd3) && outValid && $past(inValid, 3) &&
     (($past(opcode, 3) == 3'd1) || ($past(opcode, 3) == 3'd3)))
    |-> (result[127:32] == '0)); // R3

  AST_UPPER_LANES_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((rstAge == 2'd3) && outValid && $past(inValid, 3) &&
     ($past(opcode, 3) != 3'd4) && ($past(opcode, 3) != 3'd6))
    |-> (result[127:64] == '0)); // R4

endmodule

bind cmx_mul_unit cmx_mul_unit_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opcode   (opcode),
  .outValid (outValid),
  .result   (result)
);

// File: tb/cmx_mul_unit_bench.sv
`timescale 1ns/1ps
module cmx_mul_unit_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [2:0]   opcode = '0;
  logic [63:0]  opA = '0;
  logic [127:0] opB = '0;
  logic         outValid;
  logic [127:0] result;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cmx_mul_unit u_cmx_mul_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  localparam int NV = 10;
  localparam logic [194:0] STIM [NV] = '{
    {3'd0, 64'h0000_0000_5A5A_C3C3, 128'h0000_0000_0000_0000_0000_0000_7FFF_8000},
    {3'd0, 64'h0000_0000_1234_ABCD, 128'h0000_0000_0000_0000_0000_0000_8001_7FFF},
    {3'd1, 64'h0000_0000_4000_C000, 128'h0000_0000_0000_0000_0000_0000_2000_E000},
    {3'd1, 64'h0000_0000_8000_8000, 128'h0000_0000_0000_0000_0000_0000_8000_7FFF},
    {3'd2, 64'h7FFF_0001_8000_4000, 128'h0000_0000_0000_0000_1111_2222_3333_4444},
    {3'd3, 64'h0000_0000_1234_5678, 128'h0000_0000_0000_0000_0000_0000_9ABC_DEF0},
    {3'd4, 64'h1000_F000_7FFF_8000, 128'h0101_0202_8000_8000_7FFF_7FFF_3000_D000},
    {3'd5, 64'hC000_2000_0F0F_F0F0, 128'h4000_4000_C000_4000_7FFF_0000_8000_1234},
    {3'd6, 64'h8000_7FFF_2345_9876, 128'hFFFF_0001_8000_8000_0400_FC00_7FFF_8001},
    {3'd7, 64'h7FFF_7FFF_8000_8000, 128'h8000_0000_0000_8000_1357_9BDF_7FFF_7FFF}
  };

  // ---------- reference built from the requirements ----------
  function automatic logic [15:0] rnd(input longint v);
    longint t;
    t = (v + 64'sd32768) >>> 16;
    if (t > 32767)  t = 32767;
    if (t < -32768) t = -32768;
    return t[15:0];
  endfunction

  function automatic logic [31:0] s32(input longint v);
    longint t;
    t = v;
    if (t > 64'sd2147483647)  t = 64'sd2147483647;
    if (t < -64'sd2147483648) t = -64'sd2147483648;
    return t[31:0];
  endfunction

  function automatic void cm(input longint ar, input longint ai, input longint br,
                             input longint bi, output longint pr, output longint pi);
    pr = ar * br - ai * bi;
    pi = ar * bi + ai * br;
  endfunction

  function automatic logic [127:0] refModel(input logic [2:0] op, input logic [63:0] a,
                                            input logic [127:0] b);
    longint xr[2], xi[2], yr[4], yi[4];
    longint pr, pi, qr, qi, sr, si, ur, ui;
    logic [127:0] r;
    for (int k = 0; k < 2; k++) begin
      xr[k] = longint'($signed(a[32*k+16 +: 16]));
      xi[k] = longint'($signed(a[32*k +: 16]));
    end
    for (int k = 0; k < 4; k++) begin
      yr[k] = longint'($signed(b[32*k+16 +: 16]));
      yi[k] = longint'($signed(b[32*k +: 16]));
    end
    r = '0;
    case (op)
      3'd0: begin cm(xr[0], xi[0], yr[0], yi[0], pr, pi); r[31:0] = s32(pr); r[63:32] = s32(pi); end
      3'd1: begin cm(xr[0], xi[0], yr[0], yi[0], pr, pi); r[31:0] = {rnd(pr), rnd(pi)}; end
      3'd2: begin
        cm(xr[0], xi[0], yr[0], yi[0], pr, pi); r[31:0]  = {rnd(pr), rnd(pi)};
        cm(xr[1], xi[1], yr[1], yi[1], qr, qi); r[63:32] = {rnd(qr), rnd(qi)};
      end
      3'd3: begin cm(xr[0], xi[0], yr[0], -yi[0], pr, pi); r[31:0] = {rnd(pr), rnd(pi)}; end
      default: begin
        if (op[1]) begin xi[0] = -xi[0]; xi[1] = -xi[1]; end
        cm(xr[0], xi[0], yr[0], yi[0], pr, pi);
        cm(xr[1], xi[1], yr[2], yi[2], qr, qi);
        cm(xr[0], xi[0], yr[1], yi[1], sr, si);
        cm(xr[1], xi[1], yr[3], yi[3], ur, ui);
        if (op[0]) begin
          r[31:0]  = {rnd(pr + qr), rnd(pi + qi)};
          r[63:32] = {rnd(sr + ur), rnd(si + ui)};
        end else begin
          r[31:0]   = s32(pr + qr);
          r[63:32]  = s32(pi + qi);
          r[95:64]  = s32(sr + ur);
          r[127:96] = s32(si + ui);
        end
      end
    endcase
    return r;
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [63:0] a,
                       input logic [127:0] b);
    inValid = v; opcode = op; opA = a; opB = b;
  endtask

  task automatic runOne(input string tag, input logic [2:0] op, input logic [63:0] a,
                        input logic [127:0] b, input logic [127:0] exp);
    @(negedge clk); drive(1'b1, op, a, b);
    @(negedge clk); drive(1'b0, 3'd0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    chk({tag, " valid"}, {127'd0, outValid}, 128'd1);
    chk(tag, result, exp);
  endtask

  logic [127:0] expTab [NV];

  initial begin
    for (int i = 0; i < NV; i++)
      expTab[i] = refModel(STIM[i][194:192], STIM[i][191:128], STIM[i][127:0]);

    // reset state, R10
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {127'd0, outValid}, '0);
    chk("R10 reset result", result, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 after release", {127'd0, outValid}, '0);

    // streamed table, back to back, R1 and R9
    for (int t = 0; t < NV + 3; t++) begin
      @(negedge clk);
      if (t >= 3) begin
        chk($sformatf("R9 stream valid %0d", t - 3), {127'd0, outValid}, 128'd1);
        chk($sformatf("R1 %s vec %0d", opTag(STIM[t-3][194:192]), t - 3), result, expTab[t-3]);
      end
      if (t < NV) drive(1'b1, STIM[t][194:192], STIM[t][191:128], STIM[t][127:0]);
      else        drive(1'b0, 3'd0, '0, '0);
    end
    @(negedge clk);
    chk("R10 idle valid", {127'd0, outValid}, '0);
    chk("R10 idle result", result, '0);

    // latency window, R9
    @(negedge clk); drive(1'b1, 3'd1, 64'h0000_0000_4000_0000, 128'h4000_0000);
    @(negedge clk); drive(1'b0, 3'd0, '0, '0);
    chk("R9 not yet +1", {127'd0, outValid}, '0);
    @(negedge clk);
    chk("R9 not yet +2", {127'd0, outValid}, '0);
    @(negedge clk);
    chk("R9 at +3", {127'd0, outValid}, 128'd1);
    chk("R3 half squared", result, {96'd0, 32'h1000_0000});

    // rounding ties, R3
    runOne("R3 tie plus", 3'd1, 64'h0000_0000_FFFF_0000, 128'h8000_0000, {96'd0, 32'h0001_0000});
    runOne("R3 tie minus", 3'd1, 64'h0000_0000_0001_0000, 128'h8000_0000, {96'd0, 32'h0000_0000});
    // dual, R4
    runOne("R4 dual", 3'd2, 64'h0000_4000_4000_0000,
           128'h0000_0000_0000_0000_0000_4000_4000_0000, {64'd0, 32'hF000_0000, 32'h1000_0000});
    // conjugate saturation, R5
    runOne("R5 conj sat", 3'd3, 64'h0000_0000_8000_8000, 128'h8000_8000, {96'd0, 32'h7FFF_0000});
    // matrix saturation, R6 and R7
    runOne("R6 mat sat", 3'd4, 64'h8000_0000_8000_0000,
           {4{32'h8000_0000}}, {32'h0, 32'h7FFF_FFFF, 32'h0, 32'h7FFF_FFFF});
    runOne("R7 mat rnd sat", 3'd5, 64'h8000_0000_8000_0000,
           {4{32'h8000_0000}}, {64'd0, 32'h7FFF_0000, 32'h7FFF_0000});
    // conjugated vector, R8: conj((0,0.5)) * (0,0.5) = 0.25 for both columns
    runOne("R8 conj vec", 3'd7, 64'h0000_0000_0000_4000,
           128'h0000_0000_0000_0000_0000_4000_0000_4000, {64'd0, 32'h1000_0000, 32'h1000_0000});

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule